// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds or subtracts two single-precision binary floating-point numbers in a four-stage pipeline. The first stage compares the operands, orders them by magnitude and shifts the smaller significand right until the exponents agree. The second stage adds or subtracts the aligned significands. The third stage normalizes the raw result and checks the exponent range. The fourth stage rounds to nearest-even and renormalizes if rounding carries out of the significand.

An operand pair with its add/subtract select is accepted on any cycle its valid strobe is high. The result, its valid strobe and the overflow and underflow flags appear exactly four cycles later. A new pair may enter on every cycle. Denormal inputs count as zero. A NaN operand, or a sum of opposite-signed infinities, yields one canonical quiet NaN.

Top module: `fp_add_pipe`

## Requirements
- R1: A pair presented with `in_valid` high on a clock edge produces `out_valid` high, with its result and flags, exactly four edges later. Back-to-back pairs are accepted every cycle and come out in order.
- R2: The operand with the smaller exponent is shifted right to the larger exponent before the add, so operands with different exponents sum exactly when the result fits (1.5 + 0.25 = 0x3FE00000).
- R3: `op_sub` = 1 inverts the sign of `op_b` (bit 31). The significands are subtracted when the effective signs differ, and the result takes the sign of the operand with the larger magnitude.
- R4: Cancellation is normalized by a left shift of several places with a matching exponent decrease (0x3F000000 + 0xBEE00000 = 0x3D800000).
- R5: The result is rounded to nearest using guard, round and sticky bits. An exact half-way case rounds to the even significand (0x3F800000 + 0x33800000 = 0x3F800000; 0x3F800001 + 0x33800000 = 0x3F800002).
- R6: When rounding carries out of the significand, the result is renormalized and the exponent rises by one (0x3F7FFFFF + 0x33000000 = 0x3F800000).
- R7: A biased exponent at or above 255 after normalization or after rounding gives signed infinity (exponent field all ones, fraction zero) and sets `out_ovf`.
- R8: A biased exponent at or below 0 after normalization gives signed zero and sets `out_unf`. `out_ovf` and `out_unf` are never both set.
- R9: An exact zero from operands of opposite effective sign is +0 (0x00000000). The sum of two zeros of the same effective sign keeps that sign.
- R10: An operand with exponent field 0 is treated as zero whatever its fraction, and no result has exponent field 0 with a nonzero fraction.
- R11: A NaN operand, or infinities of opposite effective sign, gives 0x7FC00000. An infinity plus a finite value gives that infinity. In both cases the flags are clear.
- R12: While `rst` is high and afterwards until the first valid pair emerges, `out_valid`, `out_ovf` and `out_unf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair valid |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 selects op_a minus op_b |
| out_valid | output | 1 | Result valid |
| out_sum | output | 32 | Rounded result |
| out_ovf | output | 1 | Overflow: result forced to infinity |
| out_unf | output | 1 | Underflow: result forced to zero |

## Verification
The bench builds the adder with its default 8-bit exponent and 23-bit fraction. At these values its exact wide-integer reference model is an ordinary single-precision adder. This reaches the largest finite value for rounding and sum overflow, the smallest normal for underflow, and alignment distances large enough to move the whole smaller significand into the sticky bit. A randomized stream with close and distant exponents, sent without gaps, exercises tie rounding and deep cancellation at one result per cycle.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  // Operand class carried down the pipe next to the data.
  typedef enum logic [1:0] {
    CLS_NUM  = 2'd0,  // ordinary arithmetic path
    CLS_ZERO = 2'd1,  // both operands zero (after flushing)
    CLS_SPEC = 2'd2   // infinity or NaN result chosen in stage one
  } fpa_cls_e;
endpackage

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_v,
  input  logic [EXP_W+MAN_W:0]     a,
  input  logic [EXP_W+MAN_W:0]     b,
  input  logic                     sub,
  output logic                     o_v,
  output logic                     o_sign,
  output logic [EXP_W-1:0]         o_exp,
  output logic [MAN_W+3:0]         o_big,
  output logic [MAN_W+3:0]         o_small,
  output logic                     o_esub,
  output fpa_cls_e                 o_cls,
  output logic [EXP_W+MAN_W:0]     o_spec
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int ALN_W = MAN_W + 4;
  localparam logic [EXP_W-1:0] EMAX = '1;

  // Right shift that folds every bit lost into the lowest position.
  function automatic logic [ALN_W-1:0] shr_sticky(input logic [ALN_W-1:0] v,
                                                  input logic [EXP_W-1:0] amt);
    logic [ALN_W-1:0] mask;
    if (int'(amt) >= ALN_W) return {{(ALN_W-1){1'b0}}, |v};
    mask = ~({ALN_W{1'b1}} << amt);
    return (v >> amt) | {{(ALN_W-1){1'b0}}, |(v & mask)};
  endfunction

  logic             sa, sb, za, zb, nan_a, nan_b, inf_a, inf_b, a_big;
  logic [EXP_W-1:0] ea, eb, e_hi, e_lo;
  logic [MAN_W-1:0] ma, mb;
  logic [ALN_W-1:0] sig_a, sig_b, sig_hi, sig_lo;
  fpa_cls_e         cls_c;
  logic [W-1:0]     spec_c;

  always_comb begin
    sa    = a[W-1];
    sb    = b[W-1] ^ sub;
    ea    = a[W-2:MAN_W];
    eb    = b[W-2:MAN_W];
    ma    = a[MAN_W-1:0];
    mb    = b[MAN_W-1:0];
    za    = (ea == '0);
    zb    = (eb == '0);
    nan_a = (ea == EMAX) && (ma != '0);
    nan_b = (eb == EMAX) && (mb != '0);
    inf_a = (ea == EMAX) && (ma == '0);
    inf_b = (eb == EMAX) && (mb == '0);
    sig_a = za ? '0 : {1'b1, ma, 3'b000};
    sig_b = zb ? '0 : {1'b1, mb, 3'b000};
    a_big = (za ? '0 : {ea, ma}) >= (zb ? '0 : {eb, mb});
    e_hi   = a_big ? ea : eb;
    e_lo   = a_big ? eb : ea;
    sig_hi = a_big ? sig_a : sig_b;
    sig_lo = a_big ? sig_b : sig_a;
    spec_c = '0;
    if (nan_a || nan_b || (inf_a && inf_b && (sa != sb))) begin
      cls_c  = CLS_SPEC;
      spec_c = {1'b0, EMAX, 1'b1, {(MAN_W-1){1'b0}}};
    end else if (inf_a || inf_b) begin
      cls_c  = CLS_SPEC;
      spec_c = {inf_a ? sa : sb, EMAX, {MAN_W{1'b0}}};
    end else if (za && zb) begin
      cls_c  = CLS_ZERO;
    end else begin
      cls_c  = CLS_NUM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) o_v <= 1'b0;
    else     o_v <= in_v;
  end

  always_ff @(posedge clk) begin
    o_cls   <= cls_c;
    o_spec  <= spec_c;
    o_sign  <= (cls_c == CLS_ZERO) ? (sa & sb) : (a_big ? sa : sb);
    o_exp   <= e_hi;
    o_big   <= sig_hi;
    o_small <= shr_sticky(sig_lo, e_hi - e_lo);
    o_esub  <= (sa != sb);
  end
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub
  import fpa_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 i_v,
  input  logic                 i_sign,
  input  logic [EXP_W-1:0]     i_exp,
  input  logic [MAN_W+3:0]     i_big,
  input  logic [MAN_W+3:0]     i_small,
  input  logic                 i_esub,
  input  fpa_cls_e             i_cls,
  input  logic [EXP_W+MAN_W:0] i_spec,
  output logic                 o_v,
  output logic                 o_sign,
  output logic [EXP_W-1:0]     o_exp,
  output logic [MAN_W+4:0]     o_sum,
  output fpa_cls_e             o_cls,
  output logic [EXP_W+MAN_W:0] o_spec
);
  // The larger magnitude is always the minuend, so the difference is never negative.
  function automatic logic [MAN_W+4:0] sig_op(input logic [MAN_W+3:0] x,
                                              input logic [MAN_W+3:0] y,
                                              input logic            minus);
    return minus ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
  endfunction

  always_ff @(posedge clk) begin
    if (rst) o_v <= 1'b0;
    else     o_v <= i_v;
  end

  always_ff @(posedge clk) begin
    o_sign <= i_sign;
    o_exp  <= i_exp;
    o_sum  <= sig_op(i_big, i_small, i_esub);
    o_cls  <= i_cls;
    o_spec <= i_spec;
  end
endmodule

// File: rtl/fpa_norm.sv
module fpa_norm
  import fpa_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 i_v,
  input  logic                 i_sign,
  input  logic [EXP_W-1:0]     i_exp,
  input  logic [MAN_W+4:0]     i_sum,
  input  fpa_cls_e             i_cls,
  input  logic [EXP_W+MAN_W:0] i_spec,
  output logic                 o_v,
  output logic                 o_sign,
  output logic [EXP_W+1:0]     o_exp,
  output logic [MAN_W+3:0]     o_sig,
  output logic                 o_zero,
  output logic                 o_ovf,
  output logic                 o_unf,
  output fpa_cls_e             o_cls,
  output logic [EXP_W+MAN_W:0] o_spec
);
  localparam int ALN_W = MAN_W + 4;
  localparam int EW2   = EXP_W + 2;
  localparam int LZ_W  = $clog2(ALN_W + 1);
  localparam int EMAX  = (1 << EXP_W) - 1;

  // Count of zeros above the most significant one.
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [ALN_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(ALN_W);
    for (int i = 0; i < ALN_W; i++)
      if (v[i]) n = LZ_W'(ALN_W - 1 - i);
    return n;
  endfunction

  logic [LZ_W-1:0]  lz;
  logic [ALN_W-1:0] sig_c;
  logic [EW2-1:0]   exp_c;

  always_comb begin
    lz = lead_zeros(i_sum[ALN_W-1:0]);
    if (i_sum[ALN_W]) begin
      sig_c = {i_sum[ALN_W:2], i_sum[1] | i_sum[0]};
      exp_c = {2'b00, i_exp} + EW2'(1);
    end else begin
      sig_c = i_sum[ALN_W-1:0] << lz;
      exp_c = {2'b00, i_exp} - EW2'(lz);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) o_v <= 1'b0;
    else     o_v <= i_v;
  end

  always_ff @(posedge clk) begin
    o_sign <= i_sign;
    o_exp  <= exp_c;
    o_sig  <= sig_c;
    o_zero <= (i_sum == '0);
    o_unf  <= exp_c[EW2-1] || (exp_c == '0);
    o_ovf  <= !exp_c[EW2-1] && (exp_c >= EW2'(EMAX));
    o_cls  <= i_cls;
    o_spec <= i_spec;
  end
endmodule

// File: rtl/fpa_round.sv
module fpa_round
  import fpa_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 i_v,
  input  logic                 i_sign,
  input  logic [EXP_W+1:0]     i_exp,
  input  logic [MAN_W+3:0]     i_sig,
  input  logic                 i_zero,
  input  logic                 i_ovf,
  input  logic                 i_unf,
  input  fpa_cls_e             i_cls,
  input  logic [EXP_W+MAN_W:0] i_spec,
  output logic                 o_v,
  output logic [EXP_W+MAN_W:0] o_res,
  output logic                 o_ovf,
  output logic                 o_unf
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int SIG_W = MAN_W + 1;
  localparam int EW2   = EXP_W + 2;
  localparam int EMAX  = (1 << EXP_W) - 1;

  // Nearest-even increment decision from the kept lsb and guard/round/sticky.
  function automatic logic rne_up(input logic lsb, input logic g,
                                  input logic r, input logic s);
    return g & (r | s | lsb);
  endfunction

  logic [SIG_W:0]   rsig;
  logic             carry;
  logic [EW2-1:0]   rexp;
  logic [W-1:0]     res_c;
  logic             ovf_c, unf_c;

  always_comb begin
    rsig  = {1'b0, i_sig[MAN_W+3:3]}
          + (SIG_W+1)'(rne_up(i_sig[3], i_sig[2], i_sig[1], i_sig[0]));
    carry = rsig[SIG_W];
    rexp  = i_exp + EW2'(carry);
    ovf_c = 1'b0;
    unf_c = 1'b0;
    if (i_cls == CLS_SPEC) begin
      res_c = i_spec;
    end else if (i_cls == CLS_ZERO) begin
      res_c = {i_sign, {(W-1){1'b0}}};
    end else if (i_zero) begin
      res_c = '0;
    end else if (i_unf) begin
      res_c = {i_sign, {(W-1){1'b0}}};
      unf_c = 1'b1;
    end else if (i_ovf || (rexp >= EW2'(EMAX))) begin
      res_c = {i_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      ovf_c = 1'b1;
    end else begin
      res_c = {i_sign, rexp[EXP_W-1:0], carry ? {MAN_W{1'b0}} : rsig[MAN_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_v   <= 1'b0;
      o_ovf <= 1'b0;
      o_unf <= 1'b0;
      o_res <= '0;
    end else begin
      o_v   <= i_v;
      o_ovf <= i_v & ovf_c;
      o_unf <= i_v & unf_c;
      o_res <= res_c;
    end
  end
endmodule

// File: rtl/fp_add_pipe.sv
module fp_add_pipe
  import fpa_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [EXP_W+MAN_W:0]     op_a,
  input  logic [EXP_W+MAN_W:0]     op_b,
  input  logic                     op_sub,
  output logic                     out_valid,
  output logic [EXP_W+MAN_W:0]     out_sum,
  output logic                     out_ovf,
  output logic                     out_unf
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int ALN_W = MAN_W + 4;
  localparam int EW2   = EXP_W + 2;

  logic             s1_v, s1_sign, s1_esub;
  logic [EXP_W-1:0] s1_exp;
  logic [ALN_W-1:0] s1_big, s1_small;
  fpa_cls_e         s1_cls;
  logic [W-1:0]     s1_spec;

  logic             s2_v, s2_sign;
  logic [EXP_W-1:0] s2_exp;
  logic [ALN_W:0]   s2_sum;
  fpa_cls_e         s2_cls;
  logic [W-1:0]     s2_spec;

  logic             s3_v, s3_sign, s3_zero, s3_ovf, s3_unf;
  logic [EW2-1:0]   s3_exp;
  logic [ALN_W-1:0] s3_sig;
  fpa_cls_e         s3_cls;
  logic [W-1:0]     s3_spec;

  // Events brought out for the checker.
  logic norm_live, norm_lead;
  assign norm_live = s3_v && (s3_cls == CLS_NUM) && !s3_zero;
  assign norm_lead = s3_sig[ALN_W-1];

  fpa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .clk(clk), .rst(rst), .in_v(in_valid), .a(op_a), .b(op_b), .sub(op_sub),
    .o_v(s1_v), .o_sign(s1_sign), .o_exp(s1_exp), .o_big(s1_big),
    .o_small(s1_small), .o_esub(s1_esub), .o_cls(s1_cls), .o_spec(s1_spec));

  fpa_addsub #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_addsub (
    .clk(clk), .rst(rst), .i_v(s1_v), .i_sign(s1_sign), .i_exp(s1_exp),
    .i_big(s1_big), .i_small(s1_small), .i_esub(s1_esub), .i_cls(s1_cls),
    .i_spec(s1_spec), .o_v(s2_v), .o_sign(s2_sign), .o_exp(s2_exp),
    .o_sum(s2_sum), .o_cls(s2_cls), .o_spec(s2_spec));

  fpa_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .clk(clk), .rst(rst), .i_v(s2_v), .i_sign(s2_sign), .i_exp(s2_exp),
    .i_sum(s2_sum), .i_cls(s2_cls), .i_spec(s2_spec), .o_v(s3_v),
    .o_sign(s3_sign), .o_exp(s3_exp), .o_sig(s3_sig), .o_zero(s3_zero),
    .o_ovf(s3_ovf), .o_unf(s3_unf), .o_cls(s3_cls), .o_spec(s3_spec));

  fpa_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
    .clk(clk), .rst(rst), .i_v(s3_v), .i_sign(s3_sign), .i_exp(s3_exp),
    .i_sig(s3_sig), .i_zero(s3_zero), .i_ovf(s3_ovf), .i_unf(s3_unf),
    .i_cls(s3_cls), .i_spec(s3_spec), .o_v(out_valid), .o_res(out_sum),
    .o_ovf(out_ovf), .o_unf(out_unf));
endmodule

// File: rtl/fpa_chk.sv
module fpa_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 s1_v,
  input logic                 s2_v,
  input logic                 s3_v,
  input logic                 out_valid,
  input logic [EXP_W+MAN_W:0] out_sum,
  input logic                 out_ovf,
  input logic                 out_unf,
  input logic                 norm_live,
  input logic                 norm_lead
);
  localparam int W = 1 + EXP_W + MAN_W;

  p_lat_s1_r1:  assert property (@(posedge clk) disable iff (rst) s1_v == $past(in_valid));
  p_lat_s2_r1:  assert property (@(posedge clk) disable iff (rst) s2_v == $past(s1_v));
  p_lat_s3_r1:  assert property (@(posedge clk) disable iff (rst) s3_v == $past(s2_v));
  p_lat_out_r1: assert property (@(posedge clk) disable iff (rst) out_valid == $past(s3_v));

  p_norm_lead_r4: assert property (@(posedge clk) disable iff (rst) norm_live |-> norm_lead);

  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (out_valid && out_sum[W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}}));

  p_unf_zero_r8: assert property (@(posedge clk) disable iff (rst)
    out_unf |-> (out_valid && out_sum[W-2:0] == '0));

  p_flag_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(out_ovf && out_unf));

  p_no_denorm_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sum[W-2:MAN_W] == '0) |-> (out_sum[MAN_W-1:0] == '0));

  p_rst_quiet_r12: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_ovf && !out_unf));
endmodule

bind fp_add_pipe fpa_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .s1_v(s1_v), .s2_v(s2_v),
  .s3_v(s3_v), .out_valid(out_valid), .out_sum(out_sum), .out_ovf(out_ovf),
  .out_unf(out_unf), .norm_live(norm_live), .norm_lead(norm_lead));

// File: tb/tb_fp_add_pipe.sv
`timescale 1ns/1ps
module tb_fp_add_pipe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        op_sub = 1'b0;
  logic        out_valid, out_ovf, out_unf;
  logic [31:0] out_sum;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    logic        unf;
    int          at;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp_add_pipe dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .out_valid(out_valid), .out_sum(out_sum),
    .out_ovf(out_ovf), .out_unf(out_unf));

  // Exact wide-integer model: {ovf, unf, result}.
  function automatic logic [33:0] model(logic [31:0] a, logic [31:0] b, logic sub);
    logic sa, sb2, ts;
    int ea, eb, te, d, p, sh, e0, e1;
    logic [22:0] ma, mb, tm;
    logic [127:0] x, y, z, keep, rem, half;
    sa = a[31]; sb2 = b[31] ^ sub;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    ma = a[22:0]; mb = b[22:0];
    if ((ea == 255 && ma != 0) || (eb == 255 && mb != 0)) return {2'b00, 32'h7FC00000};
    if (ea == 255 && eb == 255)
      return (sa != sb2) ? {2'b00, 32'h7FC00000} : {2'b00, sa, 8'hFF, 23'd0};
    if (ea == 255) return {2'b00, sa, 8'hFF, 23'd0};
    if (eb == 255) return {2'b00, sb2, 8'hFF, 23'd0};
    if (ea == 0 && eb == 0) return {2'b00, sa & sb2, 31'd0};
    if (ea == 0) return {2'b00, sb2, b[30:0]};
    if (eb == 0) return {2'b00, sa, a[30:0]};
    if ({b[30:23], mb} > {a[30:23], ma}) begin
      ts = sa; sa = sb2; sb2 = ts;
      te = ea; ea = eb; eb = te;
      tm = ma; ma = mb; mb = tm;
    end
    d = ea - eb;
    if (d > 60) return {2'b00, sa, 8'(ea), ma};
    x = {104'd0, 1'b1, ma} << d;
    y = {104'd0, 1'b1, mb};
    z = (sa != sb2) ? x - y : x + y;
    if (z == 0) return 34'd0;
    p = 0;
    for (int i = 0; i < 128; i++) if (z[i]) p = i;
    e0 = eb + p - 23;
    if (e0 <= 0) return {2'b01, sa, 31'd0};
    if (p > 23) begin
      sh   = p - 23;
      keep = z >> sh;
      rem  = z & ((128'd1 << sh) - 1);
      half = 128'd1 << (sh - 1);
      if (rem > half || (rem == half && keep[0])) keep = keep + 1;
    end else begin
      keep = z << (23 - p);
    end
    e1 = e0;
    if (keep[24]) begin keep = keep >> 1; e1 = e1 + 1; end
    if (e1 >= 255) return {2'b10, sa, 8'hFF, 23'd0};
    return {2'b00, sa, 8'(e1), keep[22:0]};
  endfunction

  // Driver: called at a falling edge, leaves one cycle later.
  task automatic send(logic [31:0] a, logic [31:0] b, logic s, string req);
    exp_t it;
    logic [33:0] m;
    m = model(a, b, s);
    op_a = a; op_b = b; op_sub = s; in_valid = 1'b1;
    it.res = m[31:0]; it.ovf = m[33]; it.unf = m[32]; it.at = cyc + 4; it.req = req;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops and compares each result as it emerges.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        chk("R1 unexpected valid", 36'd1, 36'd0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        chk(it.req, {out_ovf, out_unf, out_sum}, {it.ovf, it.unf, it.res});
        chk("R1 latency", 36'(cyc), 36'(it.at));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R12 reset outputs", {33'd0, out_valid, out_ovf, out_unf}, 36'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 after reset", {33'd0, out_valid, out_ovf, out_unf}, 36'd0);

    send(32'h3FC00000, 32'h3E800000, 1'b0, "R2 align 1.5+0.25");
    send(32'h40400000, 32'h3F800000, 1'b1, "R3 sub 3-1");
    send(32'h3F800000, 32'hC0400000, 1'b0, "R3 sign of larger");
    send(32'h3F000000, 32'hBEE00000, 1'b0, "R4 cancellation");
    send(32'h3F800000, 32'h33800000, 1'b0, "R5 tie to even down");
    send(32'h3F800001, 32'h33800000, 1'b0, "R5 tie to even up");
    send(32'h3F7FFFFF, 32'h33000000, 1'b0, "R6 round carry");
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R7 sum overflow");
    send(32'h7F7FFFFF, 32'h73000000, 1'b0, "R7 rounding overflow");
    send(32'h00800000, 32'h00C00000, 1'b1, "R8 underflow");
    send(32'h40490FDB, 32'hC0490FDB, 1'b0, "R9 x-x");
    send(32'h80000000, 32'h80000000, 1'b0, "R9 -0+-0");
    send(32'h80000000, 32'h00000000, 1'b1, "R9 -0 minus +0");
    send(32'h00000001, 32'h3F800000, 1'b0, "R10 denorm flush");
    send(32'h007FFFFF, 32'h807FFFFF, 1'b0, "R10 denorm pair");
    send(32'h7FC00001, 32'h3F800000, 1'b0, "R11 NaN in");
    send(32'h7F800000, 32'h7F800000, 1'b1, "R11 inf-inf");
    send(32'hFF800000, 32'h3F800000, 1'b0, "R11 inf+finite");
    repeat (2) @(negedge clk);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      int eb;
      a = $urandom;
      b = $urandom;
      if (i % 2 == 0) begin
        eb = int'(a[30:23]) + int'($urandom_range(0, 30)) - 15;
        if (eb < 1) eb = 1;
        if (eb > 254) eb = 254;
        b[30:23] = 8'(eb);
      end
      send(a, b, 1'($urandom_range(0, 1)), "R5 random stream");
    end
    repeat (8) @(negedge clk);
    chk("R1 drained", 36'(sb.size()), 36'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule